// File: doc/BRIEF.md
# Ethernet Transmit Status Tracker

This block runs next to a half-duplex 10/100 Ethernet transmit engine and keeps one status word for the frame in flight and the frame that last finished. It watches the engine's frame boundaries, carrier sense, collisions, the end of the preamble and a broadcast indication. From these it timestamps each event in byte times and raises flags for excessive deferral, late collision, lost carrier, deferral inside the inter-frame gap and broadcast frames. It also raises flags for statistics counter rollover and for link state. When a frame finishes, the block copies the status word out, so that it can be written as the first word of that frame's buffer.

A CPU writes a small control field. This field holds transmit-enable, force-collision and carrier-monitor enable. The CPU reads the status word and clears the rollover flag through a counter-register read strobe. A late collision or a lost carrier stops transmission by clearing transmit-enable without CPU action. The byte-time clock comes from an internal divider. The divider has one ratio for each link speed, so the collision window, the deferral limit and the gap window all follow the selected speed.

Top module: `eth_tx_status_tracker`

## Requirements
- R1: A byte tick is produced every DIV_100 clocks when `speed_100` is 1 and every DIV_10 clocks when it is 0. All byte-time thresholds count these ticks, so a collision 50 byte times into a frame at 10 Mbps is early while the same clock count at 100 Mbps would be late.
- R2: Status bit 2 (excessive deferral) sets once the engine has waited with a frame pending and carrier present for more than DEFER_LIMIT (3036) byte times. It clears at every frame end.
- R3: A collision more than LATE_BYTES (64) byte times after frame start sets status bit 0 (late collision), pulses `jam` and clears transmit-enable. An earlier collision leaves all three unchanged.
- R4: With carrier monitoring on, a missing carrier at end of preamble sets status bit 1 (lost carrier) and clears transmit-enable. With monitoring off, the same event has no effect.
- R5: Status bits 0 and 1 clear only on a control write whose enable bit (bit 0) is 1. A write with enable 0 keeps them.
- R6: Status bit 3 (deferred) sets when carrier is seen within the inter-frame window (IFG_BYTES_100 or IFG_BYTES_10 byte times after frame end). It clears at every frame end. Carrier after the window does not set it.
- R7: Status bit 4 (last broadcast) is loaded from `frame_bcast` at each accepted frame start.
- R8: Status bit 6 is the inverted, two-flop-synchronised `link_n`. Each change of it gives a one-cycle `link_irq` pulse.
- R9: Status bit 5 (rollover) sets on `cnt_max_hit` and clears on `cnt_rd`.
- R10: Clearing enable during a frame keeps `tx_run` high until that frame ends. While enable is 0, `tx_start` is ignored and the status word is held.
- R11: One cycle after a frame end, `snap_valid` pulses and `snap_word` carries the status word as it stood before the end-of-frame clears.
- R12: With force (control bit 1) and enable set and no frame active, the next carrier gives a single `force_go` pulse. `force_sfd` is 1 with it only when `tx_pending` is 1. A new control write re-arms it. Nothing is produced with enable 0.
- R13: After reset the status word is 0, with layout {enable, link_ok, rollover, last_bcast, deferred, exc_deferral, lost_carrier, late_collision} from bit 7 down to bit 0. Control bit 2 is the carrier-monitor enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| speed_100 | input | 1 | 1 selects 100 Mbps byte timing |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 3 | {monitor, force, enable} |
| cnt_rd | input | 1 | Counter register read strobe |
| cnt_max_hit | input | 1 | A statistics counter reached 15 |
| tx_start | input | 1 | Engine begins a frame |
| tx_end | input | 1 | Engine finished the frame |
| tx_pending | input | 1 | A frame is queued |
| frame_bcast | input | 1 | Frame being started is broadcast |
| preamble_done | input | 1 | End of preamble strobe |
| carrier | input | 1 | Carrier sense |
| collision | input | 1 | Collision detect |
| link_n | input | 1 | Active-low link pin |
| status | output | 8 | Status word |
| tx_en | output | 1 | Transmit-enable bit |
| tx_run | output | 1 | Enable or frame still active |
| force_go | output | 1 | Transmit without deferral now |
| force_sfd | output | 1 | Forced transmit includes SFD |
| jam | output | 1 | Late-collision jam pulse |
| link_irq | output | 1 | Link change pulse |
| snap_valid | output | 1 | Snapshot strobe |
| snap_word | output | 8 | Status snapshot for packet memory |

## Verification
Collisions are injected at two offsets on each side of the 64-byte window. The same clock offset is then replayed at the slower speed, which shows whether the thresholds count byte ticks or raw clocks. Deferral is held just below and just above the 3036-byte limit. Carrier is raised inside and outside the gap window, which tells a window-bounded check from an unbounded one. Frame ends are used to confirm that the snapshot keeps the flags that the same edge clears. The force-collision path is tried with and without a queued frame and with enable off.

// File: rtl/eth_tx_status_tracker.sv
module eth_tx_status_tracker #(
  parameter int DIV_100       = 10,
  parameter int DIV_10        = 100,
  parameter int IFG_BYTES_100 = 80,
  parameter int IFG_BYTES_10  = 8,
  parameter int LATE_BYTES    = 64,
  parameter int DEFER_LIMIT   = 3036
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic       ctl_wr,
  input  logic [2:0] ctl_wdata,
  input  logic       cnt_rd,
  input  logic       cnt_max_hit,
  input  logic       tx_start,
  input  logic       tx_end,
  input  logic       tx_pending,
  input  logic       frame_bcast,
  input  logic       preamble_done,
  input  logic       carrier,
  input  logic       collision,
  input  logic       link_n,
  output logic [7:0] status,
  output logic       tx_en,
  output logic       tx_run,
  output logic       force_go,
  output logic       force_sfd,
  output logic       jam,
  output logic       link_irq,
  output logic       snap_valid,
  output logic [7:0] snap_word
);
  localparam int DIV_MAX = (DIV_10 > DIV_100) ? DIV_10 : DIV_100;
  localparam int DIVW    = $clog2(DIV_MAX + 1);
  localparam int IFG_MAX = (IFG_BYTES_10 > IFG_BYTES_100) ? IFG_BYTES_10 : IFG_BYTES_100;
  localparam int IFGW    = $clog2(IFG_MAX + 1);
  localparam int POSW    = $clog2(LATE_BYTES + 2);
  localparam int DEFW    = $clog2(DEFER_LIMIT + 2);

  logic [DIVW-1:0] div_cnt;
  logic [DIVW-1:0] div_lim;
  logic            tick;
  logic [POSW-1:0] pos_cnt;
  logic [DEFW-1:0] defer_cnt;
  logic [IFGW-1:0] ifg_cnt;
  logic active, force_col, mon_csn, fc_done;
  logic lat_col, lost_carr, exc_def, tx_defr, last_bcast, cnt_roll;
  logic lk_s1, lk_s2, lk_prev;
  logic start_ok, frame_end, late_hit, lost_hit, en_wr, deferring, go;

  assign div_lim   = speed_100 ? DIVW'(DIV_100 - 1) : DIVW'(DIV_10 - 1);
  assign tick      = (div_cnt >= div_lim);
  assign start_ok  = tx_start && tx_en && !active;
  assign frame_end = tx_end && active;
  assign late_hit  = active && collision && (pos_cnt > POSW'(LATE_BYTES));
  assign lost_hit  = active && preamble_done && mon_csn && !carrier;
  assign en_wr     = ctl_wr && ctl_wdata[0];
  assign deferring = tx_pending && carrier && !active;
  assign go        = force_col && tx_en && carrier && !fc_done && !active;

  assign status   = {tx_en, lk_s2, cnt_roll, last_bcast, tx_defr, exc_def, lost_carr, lat_col};
  assign tx_run   = tx_en || active;
  assign link_irq = lk_s2 ^ lk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= tick ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      pos_cnt <= '0;
    end else if (start_ok) begin
      active  <= 1'b1;
      pos_cnt <= '0;
    end else if (frame_end) begin
      active  <= 1'b0;
    end else if (active && tick && pos_cnt <= POSW'(LATE_BYTES)) begin
      pos_cnt <= pos_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      force_col <= 1'b0;
      mon_csn   <= 1'b0;
    end else begin
      if (ctl_wr) {mon_csn, force_col, tx_en} <= ctl_wdata;
      if (late_hit || lost_hit) tx_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_col   <= 1'b0;
      lost_carr <= 1'b0;
      jam       <= 1'b0;
    end else begin
      jam <= late_hit;
      if (en_wr) begin
        lat_col   <= 1'b0;
        lost_carr <= 1'b0;
      end
      if (late_hit) lat_col   <= 1'b1;
      if (lost_hit) lost_carr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defer_cnt <= '0;
      exc_def   <= 1'b0;
    end else if (frame_end) begin
      defer_cnt <= '0;
      exc_def   <= 1'b0;
    end else begin
      if (deferring && tick && defer_cnt <= DEFW'(DEFER_LIMIT)) defer_cnt <= defer_cnt + 1'b1;
      if (defer_cnt > DEFW'(DEFER_LIMIT)) exc_def <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifg_cnt <= '0;
      tx_defr <= 1'b0;
    end else if (frame_end) begin
      ifg_cnt <= speed_100 ? IFGW'(IFG_BYTES_100) : IFGW'(IFG_BYTES_10);
      tx_defr <= 1'b0;
    end else begin
      if (tick && ifg_cnt != '0) ifg_cnt <= ifg_cnt - 1'b1;
      if (ifg_cnt != '0 && carrier && !active) tx_defr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_bcast <= 1'b0;
      cnt_roll   <= 1'b0;
    end else begin
      if (start_ok) last_bcast <= frame_bcast;
      if (cnt_rd) cnt_roll <= 1'b0;
      if (cnt_max_hit) cnt_roll <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_s1   <= 1'b0;
      lk_s2   <= 1'b0;
      lk_prev <= 1'b0;
    end else begin
      lk_s1   <= ~link_n;
      lk_s2   <= lk_s1;
      lk_prev <= lk_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fc_done   <= 1'b0;
      force_go  <= 1'b0;
      force_sfd <= 1'b0;
    end else begin
      force_go  <= go;
      force_sfd <= go && tx_pending;
      if (ctl_wr) fc_done <= 1'b0;
      else if (go) fc_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_valid <= 1'b0;
      snap_word  <= '0;
    end else begin
      snap_valid <= frame_end;
      if (frame_end) snap_word <= status;
    end
  end

  // R3
  late_off_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(lat_col) |-> !tx_en);
  // R4
  lost_off_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(lost_carr) |-> !tx_en);
  // R11
  snap_src_chk: assert property (@(posedge clk) disable iff (!rst_n) snap_valid |-> $past(tx_end));
  // R2
  exc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) snap_valid |-> !exc_def);
  // R6
  defr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) snap_valid |-> !tx_defr);
  // R9
  roll_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt_rd && !cnt_max_hit |=> !cnt_roll);
  // R12
  force_src_chk: assert property (@(posedge clk) disable iff (!rst_n) force_go |-> $past(carrier) && $past(tx_en));
  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(tx_run) |-> $past(tx_end) || $past(ctl_wr) || $past(late_hit) || $past(lost_hit));
endmodule

// File: tb/tb_eth_tx_status_tracker.sv
module tb_eth_tx_status_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic speed_100 = 1'b1, ctl_wr = 1'b0, cnt_rd = 1'b0, cnt_max_hit = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic tx_start = 1'b0, tx_end = 1'b0, tx_pending = 1'b0, frame_bcast = 1'b0;
  logic preamble_done = 1'b0, carrier = 1'b0, collision = 1'b0, link_n = 1'b1;
  logic [7:0] status, snap_word;
  logic tx_en, tx_run, force_go, force_sfd, jam, link_irq, snap_valid;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  eth_tx_status_tracker #(.DIV_100(2), .DIV_10(4), .IFG_BYTES_100(80), .IFG_BYTES_10(8),
    .LATE_BYTES(64), .DEFER_LIMIT(3036)) dut (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cnt_rd(cnt_rd), .cnt_max_hit(cnt_max_hit), .tx_start(tx_start), .tx_end(tx_end),
    .tx_pending(tx_pending), .frame_bcast(frame_bcast), .preamble_done(preamble_done),
    .carrier(carrier), .collision(collision), .link_n(link_n), .status(status), .tx_en(tx_en),
    .tx_run(tx_run), .force_go(force_go), .force_sfd(force_sfd), .jam(jam), .link_irq(link_irq),
    .snap_valid(snap_valid), .snap_word(snap_word));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctl(input logic [2:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic start_frame(input logic bc);
    @(negedge clk); tx_start = 1'b1; frame_bcast = bc;
    @(negedge clk); tx_start = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk); tx_end = 1'b1;
    @(negedge clk); tx_end = 1'b0;
  endtask

  task automatic hit_collision();
    @(negedge clk); collision = 1'b1;
    @(negedge clk); collision = 1'b0;
  endtask

  task automatic t_reset();
    chk("R13 reset status", status, 8'h00);
    chk("R13 reset tx_run", tx_run, 0);
    chk("R11 no snapshot idle", snap_valid, 0);
  endtask

  task automatic t_late();
    ctl(3'b001);
    start_frame(0);
    idle(40);
    hit_collision();
    chk("R3 early collision no flag", status[0], 0);
    chk("R3 early collision enable kept", tx_en, 1);
    chk("R3 early collision no jam", jam, 0);
    idle(200);
    hit_collision();
    chk("R3 late jam", jam, 1);
    chk("R3 late flag", status[0], 1);
    chk("R3 late clears enable", tx_en, 0);
    end_frame();
    chk("R11 snapshot strobe", snap_valid, 1);
    chk("R11 snapshot late bit", snap_word[0], 1);
    ctl(3'b000);
    chk("R5 write enable 0 keeps late", status[0], 1);
    ctl(3'b001);
    chk("R5 write enable 1 clears late", status[0], 0);
  endtask

  task automatic t_speed();
    speed_100 = 1'b0;
    idle(4);
    ctl(3'b001);
    start_frame(0);
    idle(200);
    hit_collision();
    chk("R1 10M 50 bytes is early", status[0], 0);
    idle(100);
    hit_collision();
    chk("R1 10M 75 bytes is late", status[0], 1);
    end_frame();
    speed_100 = 1'b1;
    idle(100);
    ctl(3'b001);
  endtask

  task automatic t_defer();
    idle(400);
    @(negedge clk); tx_pending = 1'b1; carrier = 1'b1;
    idle(6000);
    chk("R2 below limit", status[2], 0);
    idle(200);
    chk("R2 above limit", status[2], 1);
    @(negedge clk); carrier = 1'b0;
    start_frame(0);
    tx_pending = 1'b0;
    end_frame();
    chk("R11 snapshot keeps exc_def", snap_word[2], 1);
    chk("R2 cleared at frame end", status[2], 0);
  endtask

  task automatic t_ifg();
    idle(400);
    start_frame(0);
    end_frame();
    idle(20);
    @(negedge clk); carrier = 1'b1;
    idle(5);
    carrier = 1'b0;
    chk("R6 carrier in gap sets", status[3], 1);
    idle(50);
    start_frame(0);
    end_frame();
    chk("R6 snapshot keeps deferred", snap_word[3], 1);
    chk("R6 cleared at frame end", status[3], 0);
    idle(300);
    @(negedge clk); carrier = 1'b1;
    idle(5);
    carrier = 1'b0;
    chk("R6 carrier after gap ignored", status[3], 0);
  endtask

  task automatic t_bcast();
    start_frame(1);
    chk("R7 broadcast loaded", status[4], 1);
    end_frame();
    start_frame(0);
    chk("R7 cleared at next start", status[4], 0);
    end_frame();
  endtask

  task automatic t_lost();
    idle(300);
    ctl(3'b101);
    start_frame(0);
    @(negedge clk); preamble_done = 1'b1;
    @(negedge clk); preamble_done = 1'b0;
    chk("R4 lost carrier flag", status[1], 1);
    chk("R4 lost carrier clears enable", tx_en, 0);
    end_frame();
    ctl(3'b100);
    chk("R5 enable 0 keeps lost", status[1], 1);
    ctl(3'b101);
    chk("R5 enable 1 clears lost", status[1], 0);
    ctl(3'b001);
    start_frame(0);
    @(negedge clk); preamble_done = 1'b1;
    @(negedge clk); preamble_done = 1'b0;
    chk("R4 monitor off ignored", status[1], 0);
    chk("R4 monitor off enable kept", tx_en, 1);
    end_frame();
  endtask

  task automatic t_link();
    for (int k = 0; k < 2; k++) begin
      int pulses = 0;
      @(negedge clk); link_n = (k == 1);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (link_irq) pulses++;
      end
      chk("R8 one irq per change", pulses, 1);
      chk("R8 link_ok follows pin", status[6], (k == 0));
    end
  endtask

  task automatic t_roll();
    @(negedge clk); cnt_max_hit = 1'b1;
    @(negedge clk); cnt_max_hit = 1'b0;
    idle(3);
    chk("R9 rollover sticky", status[5], 1);
    @(negedge clk); cnt_rd = 1'b1;
    @(negedge clk); cnt_rd = 1'b0;
    chk("R9 read clears", status[5], 0);
  endtask

  task automatic t_disable();
    logic [7:0] held;
    ctl(3'b001);
    start_frame(1);
    ctl(3'b000);
    chk("R10 enable bit cleared", tx_en, 0);
    chk("R10 frame keeps running", tx_run, 1);
    end_frame();
    chk("R10 stops after frame", tx_run, 0);
    held = status;
    start_frame(0);
    idle(3);
    chk("R10 start ignored when off", tx_run, 0);
    chk("R10 status held", status, held);
  endtask

  task automatic t_force();
    int n;
    int s;
    idle(300);
    for (int k = 0; k < 3; k++) begin
      ctl(k == 2 ? 3'b010 : 3'b011);
      tx_pending = (k == 0);
      n = 0; s = 0;
      @(negedge clk); carrier = 1'b1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (force_go) n++;
        if (force_sfd) s++;
      end
      carrier = 1'b0;
      tx_pending = 1'b0;
      chk("R12 force pulse count", n, (k == 2) ? 0 : 1);
      chk("R12 force sfd", s, (k == 0) ? 1 : 0);
      idle(5);
    end
    ctl(3'b001);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    fails++;
    $display("FAIL watchdog actual=%0d expected=done", wd);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    t_reset();
    t_late();
    t_speed();
    t_defer();
    t_ifg();
    t_bcast();
    t_lost();
    t_link();
    t_roll();
    t_disable();
    t_force();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule